// File: doc/BRIEF.md
# Load Queue with Memory-Ordering Violation Detection

This block holds the in-flight loads of an out-of-order core in a circular queue. Loads are allocated at the tail in program order, each tagged with its sequence number, and the execute stage later writes each load's effective address into its slot. When a store or a load executes, the block scans the younger loads that already hold an address. A load that shares the checked address's coarse granule has run ahead of an older memory access, and that load is reported as an ordering violation.

Only one violator is held at a time: the oldest one found so far. The pipeline reads it through a read-and-clear port to start a refetch. Retirement removes loads from the head by sequence number. A branch or exception squash removes younger loads from the tail and drops a held violator that the squash has made stale. A running total counts the reported faults.

Top module: `lqg_order_guard`

## Requirements
- R1: After reset the queue is empty: `free_slots` equals DEPTH, `lq_full` is 0, `alloc_idx` is 0, no violator is held, `chk_fault` is 0 and `viol_total` is 0.
- R2: An accepted allocation writes the load into slot `alloc_idx`, which is the current tail. The tail then advances by one modulo DEPTH+1, wrapping to 0. `free_slots` equals DEPTH+1 minus occupancy minus 1. When `lq_full` is 1 an allocation is ignored.
- R3: An address update marks the slot's address as valid. An allocation marks the new slot's address as invalid. Two addresses match when they agree in every bit above bit 7 (bits [ADDR_W-1:8]).
- R4: A store check (`chk_is_load`=0) scans from `chk_idx` up to the tail, with the tail excluded. A load check (`chk_is_load`=1) starts at the slot after `chk_idx`. Only slots with a valid address can match, and the first matching slot in scan order decides the result.
- R5: If the first match is older than the held violator (smaller sequence number), or if no violator is held, the match becomes the held violator and `chk_fault` is 1 in the cycle after the check.
- R6: If the held violator is the same age as the first match or older, `chk_fault` stays 0 and the held violator is kept.
- R7: A commit removes, in one cycle, every consecutive head entry whose sequence number is at most `commit_seq`.
- R8: A squash removes, in one cycle, every consecutive tail-side entry whose sequence number is above `squash_seq`, and moves the tail back over them.
- R9: A squash with `squash_seq` below the held violator's sequence number clears the violator.
- R10: `viol_valid`, `viol_idx` and `viol_seq` show the held violator. `viol_rd` clears it at the next edge, but a violator found in the same cycle takes its place instead.
- R11: `viol_total` increments by one with each reported fault and holds otherwise.
- R12: Within one cycle, squash takes precedence over commit, and commit takes precedence over allocation. The operation that loses has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocate a load at the tail |
| alloc_seq | input | SEQ_W | Sequence number of the allocated load |
| alloc_idx | output | IDX_W | Slot the next allocation takes (current tail) |
| lq_full | output | 1 | No free slot |
| free_slots | output | OCC_W | Usable free slots |
| aw_valid | input | 1 | Write an effective address |
| aw_idx | input | IDX_W | Slot receiving the address |
| aw_addr | input | ADDR_W | Effective address |
| chk_valid | input | 1 | Run an ordering check |
| chk_is_load | input | 1 | 1 for a load check, 0 for a store check |
| chk_idx | input | IDX_W | Load slot (load check) or tail captured at store allocation (store check) |
| chk_addr | input | ADDR_W | Address of the executing access |
| chk_fault | output | 1 | Check of previous cycle reported a violation |
| commit_valid | input | 1 | Retire head loads |
| commit_seq | input | SEQ_W | Youngest sequence number to retire |
| squash_valid | input | 1 | Squash younger loads |
| squash_seq | input | SEQ_W | Loads above this are removed |
| viol_rd | input | 1 | Read and clear the held violator |
| viol_valid | output | 1 | A violator is held |
| viol_idx | output | IDX_W | Slot of the held violator |
| viol_seq | output | SEQ_W | Sequence number of the held violator |
| viol_total | output | TOTAL_W | Count of reported faults |

## Verification
`alloc_idx` is combinational from the tail, so the bench reads it shortly after driving an allocation and before the edge that consumes it. All other effects appear one edge after the operation is driven: occupancy and `free_slots`, the held violator, `chk_fault` and `viol_total`. The bench drives each operation on a falling edge and samples 2 ns after the next rising edge, when those registers have settled. Each table row's expected values are therefore the state directly after that row's edge.

// File: rtl/lqg_pkg.sv
package lqg_pkg;

  localparam int GRAN_SHIFT = 8;

  typedef enum logic [1:0] {
    Q_IDLE   = 2'd0,
    Q_ALLOC  = 2'd1,
    Q_COMMIT = 2'd2,
    Q_SQUASH = 2'd3
  } q_op_e;

  // Circular index arithmetic: any signed offset folded into [0, phys).
  function automatic int wrap_idx(input int value, input int phys);
    return ((value % phys) + phys) % phys;
  endfunction

  // Coarse address compare: equal above the granule boundary.
  function automatic logic same_granule(input logic [63:0] a,
                                        input logic [63:0] b,
                                        input int shift);
    return (a >> shift) == (b >> shift);
  endfunction

endpackage

// File: rtl/lqg_ring.sv
module lqg_ring
  import lqg_pkg::*;
#(
  parameter int PHYS   = 8,
  parameter int IDX_W  = 3,
  parameter int OCC_W  = 4,
  parameter int SEQ_W  = 16,
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  q_op_e             op,
  input  logic [SEQ_W-1:0]  alloc_seq,
  input  logic [SEQ_W-1:0]  commit_seq,
  input  logic [SEQ_W-1:0]  squash_seq,
  input  logic              addr_we,
  input  logic [IDX_W-1:0]  addr_idx,
  input  logic [ADDR_W-1:0] addr_val,
  output logic [IDX_W-1:0]  tail,
  output logic [OCC_W-1:0]  count,
  output logic [OCC_W-1:0]  commit_n,
  output logic [OCC_W-1:0]  squash_n,
  output logic [SEQ_W-1:0]  ent_seq  [PHYS],
  output logic              ent_aval [PHYS],
  output logic [ADDR_W-1:0] ent_addr [PHYS]
);

  logic [IDX_W-1:0] head;

  // Retirement run length from the head.
  always_comb begin
    logic go;
    int   pos;
    commit_n = '0;
    go = 1'b1;
    for (int k = 0; k < PHYS; k++) begin
      pos = wrap_idx(int'(head) + k, PHYS);
      if (go && (k < int'(count)) && (ent_seq[pos] <= commit_seq))
        commit_n = commit_n + OCC_W'(1);
      else
        go = 1'b0;
    end
  end

  // Squash run length from the tail backwards.
  always_comb begin
    logic go;
    int   pos;
    squash_n = '0;
    go = 1'b1;
    for (int k = 0; k < PHYS; k++) begin
      pos = wrap_idx(int'(tail) - 1 - k, PHYS);
      if (go && (k < int'(count)) && (ent_seq[pos] > squash_seq))
        squash_n = squash_n + OCC_W'(1);
      else
        go = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head  <= '0;
      tail  <= '0;
      count <= '0;
      for (int i = 0; i < PHYS; i++) begin
        ent_seq[i]  <= '0;
        ent_aval[i] <= 1'b0;
        ent_addr[i] <= '0;
      end
    end else begin
      if (addr_we) begin
        ent_aval[addr_idx] <= 1'b1;
        ent_addr[addr_idx] <= addr_val;
      end
      unique case (op)
        Q_ALLOC: begin
          if (count < OCC_W'(PHYS - 1)) begin
            ent_seq[tail]  <= alloc_seq;
            ent_aval[tail] <= 1'b0;
            tail  <= IDX_W'(wrap_idx(int'(tail) + 1, PHYS));
            count <= count + OCC_W'(1);
          end
        end
        Q_COMMIT: begin
          head  <= IDX_W'(wrap_idx(int'(head) + int'(commit_n), PHYS));
          count <= count - commit_n;
        end
        Q_SQUASH: begin
          tail  <= IDX_W'(wrap_idx(int'(tail) - int'(squash_n), PHYS));
          count <= count - squash_n;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/lqg_scan.sv
module lqg_scan
  import lqg_pkg::*;
#(
  parameter int PHYS   = 8,
  parameter int IDX_W  = 3,
  parameter int SEQ_W  = 16,
  parameter int ADDR_W = 32
) (
  input  logic              chk_valid,
  input  logic              chk_is_load,
  input  logic [IDX_W-1:0]  chk_idx,
  input  logic [ADDR_W-1:0] chk_addr,
  input  logic [IDX_W-1:0]  tail,
  input  logic [SEQ_W-1:0]  ent_seq  [PHYS],
  input  logic              ent_aval [PHYS],
  input  logic [ADDR_W-1:0] ent_addr [PHYS],
  input  logic              held_valid,
  input  logic [SEQ_W-1:0]  held_seq,
  output logic              hit,
  output logic [IDX_W-1:0]  hit_idx,
  output logic [SEQ_W-1:0]  hit_seq,
  output logic              take
);

  int start;
  int span;

  always_comb begin
    start = chk_is_load ? wrap_idx(int'(chk_idx) + 1, PHYS) : int'(chk_idx);
    span  = wrap_idx(int'(tail) - start, PHYS);
  end

  // First address-valid granule match in scan order.
  always_comb begin
    int pos;
    hit     = 1'b0;
    hit_idx = '0;
    hit_seq = '0;
    for (int k = 0; k < PHYS; k++) begin
      pos = wrap_idx(start + k, PHYS);
      if (!hit && (k < span) && ent_aval[pos] &&
          same_granule(64'(ent_addr[pos]), 64'(chk_addr), GRAN_SHIFT)) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(pos);
        hit_seq = ent_seq[pos];
      end
    end
  end

  assign take = chk_valid && hit && (!held_valid || (hit_seq < held_seq));

endmodule

// File: rtl/lqg_violator.sv
module lqg_violator #(
  parameter int IDX_W   = 3,
  parameter int SEQ_W   = 16,
  parameter int TOTAL_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               take,
  input  logic [IDX_W-1:0]   hit_idx,
  input  logic [SEQ_W-1:0]   hit_seq,
  input  logic               rd,
  input  logic               squash,
  input  logic [SEQ_W-1:0]   squash_seq,
  output logic               v_valid,
  output logic [IDX_W-1:0]   v_idx,
  output logic [SEQ_W-1:0]   v_seq,
  output logic               fault_q,
  output logic [TOTAL_W-1:0] total
);

  logic             n_valid;
  logic [IDX_W-1:0] n_idx;
  logic [SEQ_W-1:0] n_seq;

  always_comb begin
    n_valid = v_valid;
    n_idx   = v_idx;
    n_seq   = v_seq;
    if (take) begin
      n_valid = 1'b1;
      n_idx   = hit_idx;
      n_seq   = hit_seq;
    end else if (rd) begin
      n_valid = 1'b0;
    end
    if (squash && n_valid && (squash_seq < n_seq))
      n_valid = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v_valid <= 1'b0;
      v_idx   <= '0;
      v_seq   <= '0;
      fault_q <= 1'b0;
      total   <= '0;
    end else begin
      v_valid <= n_valid;
      v_idx   <= n_idx;
      v_seq   <= n_seq;
      fault_q <= take;
      if (take) total <= total + TOTAL_W'(1);
    end
  end

endmodule

// File: rtl/lqg_order_guard.sv
module lqg_order_guard
  import lqg_pkg::*;
#(
  parameter int DEPTH   = 7,
  parameter int SEQ_W   = 16,
  parameter int ADDR_W  = 32,
  parameter int TOTAL_W = 16,
  localparam int PHYS   = DEPTH + 1,
  localparam int IDX_W  = $clog2(PHYS),
  localparam int OCC_W  = $clog2(PHYS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               alloc_valid,
  input  logic [SEQ_W-1:0]   alloc_seq,
  output logic [IDX_W-1:0]   alloc_idx,
  output logic               lq_full,
  output logic [OCC_W-1:0]   free_slots,
  input  logic               aw_valid,
  input  logic [IDX_W-1:0]   aw_idx,
  input  logic [ADDR_W-1:0]  aw_addr,
  input  logic               chk_valid,
  input  logic               chk_is_load,
  input  logic [IDX_W-1:0]   chk_idx,
  input  logic [ADDR_W-1:0]  chk_addr,
  output logic               chk_fault,
  input  logic               commit_valid,
  input  logic [SEQ_W-1:0]   commit_seq,
  input  logic               squash_valid,
  input  logic [SEQ_W-1:0]   squash_seq,
  input  logic               viol_rd,
  output logic               viol_valid,
  output logic [IDX_W-1:0]   viol_idx,
  output logic [SEQ_W-1:0]   viol_seq,
  output logic [TOTAL_W-1:0] viol_total
);

  // Named internal events.
  q_op_e             op_sel;
  logic [IDX_W-1:0]  tail;
  logic [OCC_W-1:0]  occupancy;
  logic [OCC_W-1:0]  commit_n;
  logic [OCC_W-1:0]  squash_n;
  logic              scan_hit;
  logic [IDX_W-1:0]  scan_idx;
  logic [SEQ_W-1:0]  scan_seq;
  logic              scan_take;
  logic [SEQ_W-1:0]  ent_seq  [PHYS];
  logic              ent_aval [PHYS];
  logic [ADDR_W-1:0] ent_addr [PHYS];

  always_comb begin
    if (squash_valid)      op_sel = Q_SQUASH;
    else if (commit_valid) op_sel = Q_COMMIT;
    else if (alloc_valid)  op_sel = Q_ALLOC;
    else                   op_sel = Q_IDLE;
  end

  lqg_ring #(
    .PHYS(PHYS), .IDX_W(IDX_W), .OCC_W(OCC_W), .SEQ_W(SEQ_W), .ADDR_W(ADDR_W)
  ) u_ring (
    .clk(clk), .rst_n(rst_n), .op(op_sel),
    .alloc_seq(alloc_seq), .commit_seq(commit_seq), .squash_seq(squash_seq),
    .addr_we(aw_valid), .addr_idx(aw_idx), .addr_val(aw_addr),
    .tail(tail), .count(occupancy), .commit_n(commit_n), .squash_n(squash_n),
    .ent_seq(ent_seq), .ent_aval(ent_aval), .ent_addr(ent_addr)
  );

  lqg_scan #(
    .PHYS(PHYS), .IDX_W(IDX_W), .SEQ_W(SEQ_W), .ADDR_W(ADDR_W)
  ) u_scan (
    .chk_valid(chk_valid), .chk_is_load(chk_is_load), .chk_idx(chk_idx),
    .chk_addr(chk_addr), .tail(tail),
    .ent_seq(ent_seq), .ent_aval(ent_aval), .ent_addr(ent_addr),
    .held_valid(viol_valid), .held_seq(viol_seq),
    .hit(scan_hit), .hit_idx(scan_idx), .hit_seq(scan_seq), .take(scan_take)
  );

  lqg_violator #(
    .IDX_W(IDX_W), .SEQ_W(SEQ_W), .TOTAL_W(TOTAL_W)
  ) u_viol (
    .clk(clk), .rst_n(rst_n), .take(scan_take),
    .hit_idx(scan_idx), .hit_seq(scan_seq),
    .rd(viol_rd), .squash(op_sel == Q_SQUASH), .squash_seq(squash_seq),
    .v_valid(viol_valid), .v_idx(viol_idx), .v_seq(viol_seq),
    .fault_q(chk_fault), .total(viol_total)
  );

  assign alloc_idx  = tail;
  assign free_slots = OCC_W'(PHYS - 1) - occupancy;
  assign lq_full    = (free_slots == '0);

endmodule

// File: rtl/lqg_order_guard_chk.sv
module lqg_order_guard_chk #(
  parameter int DEPTH   = 7,
  parameter int SEQ_W   = 16,
  parameter int OCC_W   = 4,
  parameter int TOTAL_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               alloc_valid,
  input logic               commit_valid,
  input logic               squash_valid,
  input logic [SEQ_W-1:0]   squash_seq,
  input logic               chk_valid,
  input logic               viol_rd,
  input logic [OCC_W-1:0]   occupancy,
  input logic [OCC_W-1:0]   free_slots,
  input logic               chk_fault,
  input logic               viol_valid,
  input logic [SEQ_W-1:0]   viol_seq,
  input logic [TOTAL_W-1:0] viol_total
);

  // R2
  occupancy_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occupancy <= OCC_W'(DEPTH));

  // R2
  full_ignores_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (free_slots == '0 && alloc_valid && !commit_valid && !squash_valid)
      |=> (free_slots == '0));

  // R5
  fault_records_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chk_fault && !$past(squash_valid)) |-> viol_valid);

  // R11
  total_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chk_fault |-> (viol_total == $past(viol_total) + TOTAL_W'(1)));

  // R11
  total_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_fault |-> $stable(viol_total));

  // R10
  read_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (viol_rd && !chk_valid) |=> !viol_valid);

  // R9
  squash_stale_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (squash_valid && viol_valid && (squash_seq < viol_seq) && !chk_valid)
      |=> !viol_valid);

endmodule

bind lqg_order_guard lqg_order_guard_chk #(
  .DEPTH(DEPTH), .SEQ_W(SEQ_W), .OCC_W(OCC_W), .TOTAL_W(TOTAL_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid),
  .commit_valid(commit_valid), .squash_valid(squash_valid),
  .squash_seq(squash_seq), .chk_valid(chk_valid), .viol_rd(viol_rd),
  .occupancy(occupancy), .free_slots(free_slots), .chk_fault(chk_fault),
  .viol_valid(viol_valid), .viol_seq(viol_seq), .viol_total(viol_total)
);

// File: tb/sim_lqg_order_guard.sv
module sim_lqg_order_guard;

  localparam int DEPTH = 7;
  localparam int PHYS  = DEPTH + 1;

  localparam logic [2:0] OP_ALLOC = 3'd0, OP_ADDR = 3'd1, OP_CST = 3'd2,
                         OP_CLD = 3'd3, OP_COMMIT = 3'd4, OP_SQUASH = 3'd5,
                         OP_READ = 3'd6;

  typedef struct packed {
    logic [2:0]  op;
    logic [15:0] a;
    logic [31:0] addr;
    logic [3:0]  free;
    logic        fault;
    logic        vv;
    logic [15:0] vs;
  } vec_t;

  // Expected values are the state right after each row's edge.
  localparam vec_t TBL [18] = '{
    '{OP_ALLOC,  16'd10, 32'h0,    4'd6, 1'b0, 1'b0, 16'd0},
    '{OP_ALLOC,  16'd20, 32'h0,    4'd5, 1'b0, 1'b0, 16'd0},
    '{OP_ALLOC,  16'd30, 32'h0,    4'd4, 1'b0, 1'b0, 16'd0},
    '{OP_ALLOC,  16'd40, 32'h0,    4'd3, 1'b0, 1'b0, 16'd0},
    '{OP_ADDR,   16'd2,  32'h1234, 4'd3, 1'b0, 1'b0, 16'd0},
    '{OP_ADDR,   16'd3,  32'h12FF, 4'd3, 1'b0, 1'b0, 16'd0},
    '{OP_CST,    16'd1,  32'h1200, 4'd3, 1'b1, 1'b1, 16'd30},
    '{OP_CST,    16'd0,  32'h1250, 4'd3, 1'b0, 1'b1, 16'd30},
    '{OP_CLD,    16'd1,  32'h5500, 4'd3, 1'b0, 1'b1, 16'd30},
    '{OP_ADDR,   16'd1,  32'h12AA, 4'd3, 1'b0, 1'b1, 16'd30},
    '{OP_CST,    16'd1,  32'h1200, 4'd3, 1'b1, 1'b1, 16'd20},
    '{OP_READ,   16'd0,  32'h0,    4'd3, 1'b0, 1'b0, 16'd0},
    '{OP_CLD,    16'd1,  32'h1201, 4'd3, 1'b1, 1'b1, 16'd30},
    '{OP_SQUASH, 16'd25, 32'h0,    4'd5, 1'b0, 1'b0, 16'd0},
    '{OP_CST,    16'd0,  32'h1299, 4'd5, 1'b1, 1'b1, 16'd20},
    '{OP_COMMIT, 16'd15, 32'h0,    4'd6, 1'b0, 1'b1, 16'd20},
    '{OP_COMMIT, 16'd25, 32'h0,    4'd7, 1'b0, 1'b1, 16'd20},
    '{OP_READ,   16'd0,  32'h0,    4'd7, 1'b0, 1'b0, 16'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        alloc_valid = 1'b0;
  logic [15:0] alloc_seq = '0;
  logic [2:0]  alloc_idx;
  logic        lq_full;
  logic [3:0]  free_slots;
  logic        aw_valid = 1'b0;
  logic [2:0]  aw_idx = '0;
  logic [31:0] aw_addr = '0;
  logic        chk_valid = 1'b0;
  logic        chk_is_load = 1'b0;
  logic [2:0]  chk_idx = '0;
  logic [31:0] chk_addr = '0;
  logic        chk_fault;
  logic        commit_valid = 1'b0;
  logic [15:0] commit_seq = '0;
  logic        squash_valid = 1'b0;
  logic [15:0] squash_seq = '0;
  logic        viol_rd = 1'b0;
  logic        viol_valid;
  logic [2:0]  viol_idx;
  logic [15:0] viol_seq;
  logic [15:0] viol_total;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  lqg_order_guard #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_seq(alloc_seq),
    .alloc_idx(alloc_idx), .lq_full(lq_full), .free_slots(free_slots),
    .aw_valid(aw_valid), .aw_idx(aw_idx), .aw_addr(aw_addr),
    .chk_valid(chk_valid), .chk_is_load(chk_is_load), .chk_idx(chk_idx),
    .chk_addr(chk_addr), .chk_fault(chk_fault),
    .commit_valid(commit_valid), .commit_seq(commit_seq),
    .squash_valid(squash_valid), .squash_seq(squash_seq),
    .viol_rd(viol_rd), .viol_valid(viol_valid), .viol_idx(viol_idx),
    .viol_seq(viol_seq), .viol_total(viol_total)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    alloc_valid = 0; aw_valid = 0; chk_valid = 0;
    commit_valid = 0; squash_valid = 0; viol_rd = 0;
  endtask

  // Inputs are already set at a falling edge; run one edge and settle.
  task automatic step();
    @(posedge clk);
    #2;
    idle_inputs();
  endtask

  task automatic apply(input vec_t v);
    @(negedge clk);
    case (v.op)
      OP_ALLOC:  begin alloc_valid = 1; alloc_seq = v.a; end
      OP_ADDR:   begin aw_valid = 1; aw_idx = v.a[2:0]; aw_addr = v.addr; end
      OP_CST:    begin chk_valid = 1; chk_is_load = 0; chk_idx = v.a[2:0]; chk_addr = v.addr; end
      OP_CLD:    begin chk_valid = 1; chk_is_load = 1; chk_idx = v.a[2:0]; chk_addr = v.addr; end
      OP_COMMIT: begin commit_valid = 1; commit_seq = v.a; end
      OP_SQUASH: begin squash_valid = 1; squash_seq = v.a; end
      default:   viol_rd = 1;
    endcase
    step();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1 free", free_slots, DEPTH);
    check("R1 full", lq_full, 0);
    check("R1 idx", alloc_idx, 0);
    check("R1 vvalid", viol_valid, 0);
    check("R1 fault", chk_fault, 0);
    check("R1 total", viol_total, 0);

    // Table: R2 R3 R4 R5 R6 R7 R8 R9 R10
    for (int i = 0; i < 18; i++) begin
      apply(TBL[i]);
      check("R2/R7/R8 free", free_slots, TBL[i].free);
      check("R4/R5/R6 fault", chk_fault, TBL[i].fault);
      check("R5/R9/R10 vvalid", viol_valid, TBL[i].vv);
      if (TBL[i].vv) check("R5/R6 vseq", viol_seq, TBL[i].vs);
    end
    check("R11 total after table", viol_total, 4);

    // R2 wrap and full: tail is at slot 2 now
    for (int i = 0; i < DEPTH; i++) begin
      @(negedge clk);
      alloc_valid = 1; alloc_seq = 16'(100 + i);
      #1 check("R2 alloc idx", alloc_idx, (2 + i) % PHYS);
      step();
    end
    check("R2 free at full", free_slots, 0);
    check("R2 full flag", lq_full, 1);
    @(negedge clk); alloc_valid = 1; alloc_seq = 16'd107; step();
    check("R2 alloc ignored when full", free_slots, 0);
    @(negedge clk); commit_valid = 1; commit_seq = 16'd106; step();
    check("R7 commit all", free_slots, DEPTH);
    @(negedge clk); alloc_valid = 1; alloc_seq = 16'd300;
    #1 check("R2 wrapped tail", alloc_idx, 1);
    step();
    @(negedge clk); alloc_valid = 1; alloc_seq = 16'd310; step();
    @(negedge clk); aw_valid = 1; aw_idx = 3'd2; aw_addr = 32'h12FF; step();

    // R3 granule boundary: 0x1300 vs 0x12FF differ above bit 7
    @(negedge clk); chk_valid = 1; chk_is_load = 0; chk_idx = 3'd2; chk_addr = 32'h1300; step();
    check("R3 granule miss", chk_fault, 0);

    // R3 alloc cleared slot 1's old address; R10 new find beats same-cycle read
    @(negedge clk); chk_valid = 1; chk_is_load = 0; chk_idx = 3'd1; chk_addr = 32'h1250;
    viol_rd = 1; step();
    check("R10 fault", chk_fault, 1);
    check("R10 vvalid", viol_valid, 1);
    check("R3 vseq skips stale slot", viol_seq, 310);
    check("R10 vidx", viol_idx, 2);
    check("R11 total", viol_total, 5);

    // R12 squash beats alloc; R9 clears stale violator
    @(negedge clk); alloc_valid = 1; alloc_seq = 16'd320;
    squash_valid = 1; squash_seq = 16'd305; step();
    check("R12 squash over alloc", free_slots, 6);
    check("R9 violator cleared", viol_valid, 0);
    @(negedge clk); alloc_valid = 1; alloc_seq = 16'd500;
    commit_valid = 1; commit_seq = 16'd400; step();
    check("R12 commit over alloc", free_slots, 7);
    check("R11 total held", viol_total, 5);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule